// File: doc/BRIEF.md
# Graphics-Controller Extension Lock and Pixel-Clock Select

This block is the extension register file behind the indexed graphics-controller data port of a VGA-class display controller. The host first writes an index, then reads or writes the data port at that index. One index holds a lock/status register. Its low three bits form a key that opens or closes a window of six extended registers. Its upper bits return the levels of five board configuration straps.

While the window is closed, the extended registers read as all ones and ignore writes. One extended register holds a video-select value. Bit 1 of that value combines with the two-bit clock-select field taken from the miscellaneous output register. Together they produce a registered pixel-clock source code and a doubling flag, which drive a clock generator outside the block. The standard graphics-controller registers live elsewhere. For indices this block does not own, it drives zero so that an outer read mux can OR it with other sources.

Top module: `gcx_lock_clk`

## Requirements
- R1: After reset the window is locked, the key field reads 0, the video-select register is 0 and the index register is 0. During reset `clk_src_o` is 0 and `clk_dbl_o` is 0.
- R2: A data write to index 0x0F with bits 2:0 equal to 3'b101 unlocks the window. A write to 0x0F with any other value in bits 2:0 locks it. Index 0x0F is writable whether the window is locked or not.
- R3: A read of index 0x0F returns the last written key in bits 2:0, `strap_hi_i[3:0]` in bits 7:4 and `strap_x_i` in bit 3. The strap levels are those sampled at the previous clock edge. Bits 7:3 of a write to 0x0F have no effect.
- R4: While the window is locked, reads of indices 0x09 to 0x0E return 0xFF and writes to them change nothing.
- R5: While the window is unlocked, each of indices 0x09 to 0x0E reads back the last value written to it.
- R6: Reads of any index outside 0x09 to 0x0F return 0x00.
- R7: Source code mapping from `clk_sel_i`: 0 gives source 0 (25.175 MHz), 1 gives source 1 (28.636 MHz), and both 2 and 3 give source 2 (42 MHz).
- R8: For sources 0 and 1, `clk_dbl_o` is 1 when bit 1 of the video-select register (index 0x0C) is 0, and 0 when that bit is 1. Source 2 is never doubled.
- R9: `clk_src_o` and `clk_dbl_o` are registered. They take their new values at the clock edge that accepts a video-select write. After a `clk_sel_i` change, they update at the next edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| idx_we_i | input | 1 | Load the index register from `idx_i` |
| idx_i | input | 8 | Register index |
| data_we_i | input | 1 | Write `data_i` at the current index |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data at the current index (combinational) |
| clk_sel_i | input | 2 | Clock-select field of the miscellaneous output register |
| strap_hi_i | input | 4 | Configuration strap levels returned in bits 7:4 of 0x0F |
| strap_x_i | input | 1 | Configuration strap level returned in bit 3 of 0x0F |
| clk_src_o | output | 2 | Pixel-clock source code |
| clk_dbl_o | output | 1 | Pixel-clock doubling flag |

## Verification
The hardest state to show from the ports is a write that reached the window while it was locked. Such a write must leave no trace, but the ports can only read the window back after unlocking it. The bench therefore fills the window while locked, unlocks it and confirms every entry still holds its reset value. It also watches the clock outputs during a locked video-select write, because those outputs expose the register without any unlock. All eight key codes are swept against a known stored value, so a decode that accepts a near-miss key shows up as a readable window.

// File: rtl/gcx_pkg.sv
package gcx_pkg;
  typedef enum logic [1:0] {
    SRC_25M = 2'd0,
    SRC_28M = 2'd1,
    SRC_42M = 2'd2
  } clk_src_e;

  function automatic clk_src_e map_src(input logic [1:0] sel);
    case (sel)
      2'd0:    map_src = SRC_25M;
      2'd1:    map_src = SRC_28M;
      default: map_src = SRC_42M;
    endcase
  endfunction
endpackage

// File: rtl/gcx_index_dec.sv
module gcx_index_dec #(
  parameter int unsigned IW         = 8,
  parameter int unsigned KEY_W      = 3,
  parameter int unsigned LOCK_IDX   = 15,
  parameter int unsigned WIN_LO     = 9,
  parameter int unsigned WIN_HI     = 14,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 3'b101
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idx_we_i,
  input  logic [IW-1:0]    idx_wdata_i,
  input  logic             data_we_i,
  input  logic [KEY_W-1:0] key_wdata_i,
  output logic [IW-1:0]    idx_o,
  output logic             lock_hit_o,
  output logic             win_hit_o,
  output logic [KEY_W-1:0] key_o,
  output logic             unlocked_o
);
  localparam logic [IW-1:0] LockIdx = IW'(LOCK_IDX);
  localparam logic [IW-1:0] WinLo   = IW'(WIN_LO);
  localparam logic [IW-1:0] WinHi   = IW'(WIN_HI);

  logic [IW-1:0]    idx_q;
  logic [KEY_W-1:0] key_q;
  logic             key_we;

  assign key_we = data_we_i && (idx_q == LockIdx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      key_q <= '0;
    end else begin
      if (idx_we_i) idx_q <= idx_wdata_i;
      if (key_we)   key_q <= key_wdata_i;
    end
  end

  assign idx_o      = idx_q;
  assign lock_hit_o = (idx_q == LockIdx);
  assign win_hit_o  = (idx_q >= WinLo) && (idx_q <= WinHi);
  assign key_o      = key_q;
  assign unlocked_o = (key_q == UNLOCK_KEY);

  assert_unlock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we && key_wdata_i == UNLOCK_KEY) |=> unlocked_o);
  assert_relock_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we && key_wdata_i != UNLOCK_KEY) |=> !unlocked_o);
endmodule

// File: rtl/gcx_ext_bank.sv
module gcx_ext_bank #(
  parameter int unsigned IW       = 8,
  parameter int unsigned DW       = 8,
  parameter int unsigned WIN_LO   = 9,
  parameter int unsigned WIN_HI   = 14,
  parameter int unsigned VSEL_IDX = 12,
  localparam int unsigned N       = WIN_HI - WIN_LO + 1,
  localparam int unsigned VSEL_OFS = VSEL_IDX - WIN_LO
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] idx_i,
  input  logic          data_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          unlocked_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] vsel_nxt_o
);
  logic [N-1:0][DW-1:0] regs_q;
  logic [N-1:0]         hit;

  for (genvar i = 0; i < N; i++) begin : g_reg
    assign hit[i] = (idx_i == IW'(WIN_LO + i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[i] <= '0;
      else if (data_we_i && unlocked_i && hit[i]) regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++)
      if (hit[i]) rdata_o = regs_q[i];
  end

  // next-state of video select so the clock outputs land on the write edge
  assign vsel_nxt_o = (data_we_i && unlocked_i && hit[VSEL_OFS]) ? wdata_i : regs_q[VSEL_OFS];

  assert_locked_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !unlocked_i) |=> $stable(regs_q));
  assert_onehot_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: rtl/gcx_clk_sel.sv
module gcx_clk_sel
  import gcx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] clk_sel_i,
  input  logic       half_rate_i,
  output logic [1:0] clk_src_o,
  output logic       clk_dbl_o
);
  clk_src_e src_d, src_q;
  logic     dbl_d, dbl_q;

  always_comb begin
    src_d = map_src(clk_sel_i);
    dbl_d = (src_d != SRC_42M) && !half_rate_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_25M;
      dbl_q <= 1'b0;
    end else begin
      src_q <= src_d;
      dbl_q <= dbl_d;
    end
  end

  assign clk_src_o = src_q;
  assign clk_dbl_o = dbl_q;

  assert_no_dbl_42_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_dbl_o |-> (clk_src_o != SRC_42M));
  assert_sel_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_i[1] |=> (clk_src_o == SRC_42M));
endmodule

// File: rtl/gcx_lock_clk.sv
module gcx_lock_clk #(
  parameter int unsigned IW       = 8,
  parameter int unsigned DW       = 8,
  parameter int unsigned KEY_W    = 3,
  parameter int unsigned LOCK_IDX = 15,
  parameter int unsigned WIN_LO   = 9,
  parameter int unsigned WIN_HI   = 14,
  parameter int unsigned VSEL_IDX = 12,
  parameter int unsigned HALF_BIT = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_we_i,
  input  logic [IW-1:0] idx_i,
  input  logic          data_we_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  input  logic [1:0]    clk_sel_i,
  input  logic [3:0]    strap_hi_i,
  input  logic          strap_x_i,
  output logic [1:0]    clk_src_o,
  output logic          clk_dbl_o
);
  localparam int unsigned STRAP_W = DW - KEY_W;

  logic [IW-1:0]      idx_q;
  logic               lock_hit, win_hit, unlocked;
  logic [KEY_W-1:0]   key_q;
  logic [DW-1:0]      bank_rdata, vsel_nxt;
  logic [STRAP_W-1:0] strap_q;

  gcx_index_dec #(
    .IW(IW), .KEY_W(KEY_W), .LOCK_IDX(LOCK_IDX), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
    .UNLOCK_KEY(3'b101)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .idx_we_i(idx_we_i), .idx_wdata_i(idx_i),
    .data_we_i(data_we_i), .key_wdata_i(data_i[KEY_W-1:0]),
    .idx_o(idx_q), .lock_hit_o(lock_hit), .win_hit_o(win_hit),
    .key_o(key_q), .unlocked_o(unlocked)
  );

  gcx_ext_bank #(
    .IW(IW), .DW(DW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .VSEL_IDX(VSEL_IDX)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .idx_i(idx_q), .data_we_i(data_we_i), .wdata_i(data_i),
    .unlocked_i(unlocked), .rdata_o(bank_rdata), .vsel_nxt_o(vsel_nxt)
  );

  gcx_clk_sel u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clk_sel_i(clk_sel_i), .half_rate_i(vsel_nxt[HALF_BIT]),
    .clk_src_o(clk_src_o), .clk_dbl_o(clk_dbl_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strap_q <= '0;
    else         strap_q <= {strap_hi_i, strap_x_i};
  end

  always_comb begin
    if (lock_hit)     data_o = {strap_q, key_q};
    else if (win_hit) data_o = unlocked ? bank_rdata : '1;
    else              data_o = '0;
  end

  assert_locked_ff_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_hit && !unlocked) |-> (data_o == '1));
  assert_foreign_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_hit && !lock_hit) |-> (data_o == '0));
endmodule

// File: tb/gcx_lock_clk_tb.sv
`timescale 1ns/1ps
module gcx_lock_clk_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idx_we = 1'b0, data_we = 1'b0, strap_x = 1'b0;
  logic [7:0] idx = '0, wdata = '0, rdata;
  logic [1:0] clk_sel = '0, clk_src;
  logic [3:0] strap_hi = '0;
  logic       clk_dbl;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  gcx_lock_clk u_dut (
    .clk_i(clk), .rst_ni(rst_n), .idx_we_i(idx_we), .idx_i(idx),
    .data_we_i(data_we), .data_i(wdata), .data_o(rdata),
    .clk_sel_i(clk_sel), .strap_hi_i(strap_hi), .strap_x_i(strap_x),
    .clk_src_o(clk_src), .clk_dbl_o(clk_dbl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] i);
    @(negedge clk); idx_we = 1'b1; idx = i;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] d);
    set_idx(i);
    data_we = 1'b1; wdata = d;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] i, output logic [7:0] d);
    set_idx(i);
    d = rdata;
  endtask

  task automatic chk_clk(input string req, input int sel, input bit half);
    int exp_src;
    bit exp_dbl;
    exp_src = (sel >= 2) ? 2 : sel;
    exp_dbl = (sel < 2) && !half;
    chk(clk_src == 2'(exp_src), req, clk_src, exp_src);
    chk(clk_dbl == exp_dbl, req, clk_dbl, exp_dbl);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp;
    // R1 reset state
    #22;
    chk(rdata == 8'h00, "R1 index0 read", rdata, 0);
    chk(clk_src == 2'd0, "R1 src reset", clk_src, 0);
    chk(clk_dbl == 1'b0, "R1 dbl reset", clk_dbl, 0);
    @(negedge clk); rst_n = 1'b1;
    rd(8'h0F, d);
    chk(d == 8'h00, "R1 key reset", d, 0);
    rd(8'h0C, d);
    chk(d == 8'hFF, "R1 locked after reset", d, 8'hFF);
    chk_clk("R8 vsel reset doubled", 0, 1'b0);

    // R4 locked writes leave no trace
    for (int i = 9; i <= 14; i++) wr(8'(i), 8'hC3 ^ 8'(i));
    chk_clk("R4 locked vsel write ignored", 0, 1'b0);
    wr(8'h0F, 8'h05);
    for (int i = 9; i <= 14; i++) begin
      rd(8'(i), d);
      chk(d == 8'h00, "R4 locked write ignored", d, 0);
    end

    // R2 key sweep against stored value
    wr(8'h0A, 8'h5A);
    for (int k = 0; k < 8; k++) begin
      wr(8'h0F, {5'b11111, 3'(k)});
      rd(8'h0F, d);
      chk(d[2:0] == 3'(k), "R3 key readback", d[2:0], k);
      chk(d[7:3] == 5'h00, "R3 upper bits not writable", d[7:3], 0);
      rd(8'h0A, d);
      exp = (k == 5) ? 8'h5A : 8'hFF;
      chk(d == exp, "R2 key decode", d, exp);
    end
    wr(8'h0F, 8'h05);

    // R5 window readback
    for (int i = 9; i <= 14; i++) wr(8'(i), 8'(i * 17) ^ 8'hA5);
    for (int i = 9; i <= 14; i++) begin
      rd(8'(i), d);
      exp = 8'(i * 17) ^ 8'hA5;
      chk(d == exp, "R5 window readback", d, exp);
    end

    // R3 strap sweep
    set_idx(8'h0F);
    for (int s = 0; s < 32; s++) begin
      @(negedge clk); strap_hi = 4'(s >> 1); strap_x = s[0];
      @(negedge clk);
      exp = {4'(s >> 1), s[0], 3'b101};
      chk(rdata == exp, "R3 strap readback", rdata, exp);
    end

    // R6 foreign indices
    for (int i = 0; i < 256; i++) begin
      if (i >= 9 && i <= 15) continue;
      rd(8'(i), d);
      chk(d == 8'h00, "R6 foreign index zero", d, 0);
    end

    // R7 R8 clock sweep
    for (int v = 0; v < 2; v++) begin
      wr(8'h0C, 8'(v << 1) | 8'h40);
      for (int c = 0; c < 4; c++) begin
        @(negedge clk); clk_sel = 2'(c);
        @(negedge clk);
        chk_clk("R7 R8 clock map", c, v[0]);
      end
    end

    // R9 timing: vsel write lands at its own edge; sel change waits one edge
    @(negedge clk); clk_sel = 2'd1;
    @(negedge clk);
    wr(8'h0C, 8'h00);
    chk_clk("R9 vsel write edge", 1, 1'b0);
    wr(8'h0C, 8'h02);
    chk_clk("R9 vsel write edge set", 1, 1'b1);
    @(negedge clk); clk_sel = 2'd0;
    #1;
    chk_clk("R9 held before edge", 1, 1'b1);
    @(negedge clk);
    chk_clk("R9 after edge", 0, 1'b1);

    // R2 relock, R4 locked vsel write does nothing
    wr(8'h0F, 8'h03);
    rd(8'h0C, d);
    chk(d == 8'hFF, "R2 relock", d, 8'hFF);
    wr(8'h0C, 8'h00);
    chk_clk("R4 locked vsel write", 0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule